// File: doc/BRIEF.md
# Keyed-Latch Serial Frame Transmitter

This block drives a serial LED driver link made of a serial clock, one data line and a latch-enable line. Each accepted request sends one 24-bit word, most significant bit first, over exactly 24 serial clock cycles. A latch-enable line runs alongside the data. It is raised for a chosen number of trailing clock cycles of the frame. The receiving driver decodes that count as the command, so a different command costs only a different key length. The word and the data path stay the same.

The serial clock is derived from the system clock by a divider. Latch-enable is updated by a counter that runs from the same edges that move the serial clock, so its placement cannot slip against the clock. Data and latch-enable both change just after the serial clock falls. The receiver samples them on the next rising edge.

A host presents a word and a 5-bit key length together with a start pulse. It then sees a busy level while the frame is on the wire, followed by a single-cycle done pulse.

Top module: `key_frame_tx`

## Requirements
- R1: An accepted frame produces exactly 24 rising edges of `sclk_o`. Done is raised `48*HALF_DIV` system clock cycles after the edge that accepted the start.
- R2: `sdo_o` carries the captured word most significant bit first, one bit per serial clock. It changes only after a falling edge of `sclk_o` and holds steady while `sclk_o` is high, so each bit is valid at the rising edge that samples it.
- R3: With key length N in 1..24, `latch_o` is high at exactly the last N rising edges of the frame and low at all earlier ones. It holds steady while `sclk_o` is high.
- R4: Key length 0 sends the frame with `latch_o` low for the whole frame.
- R5: Key lengths 25 to 31 behave as 24: `latch_o` is high at all 24 rising edges.
- R6: Key length 2, the data-latch command, gives `latch_o` high at exactly the final two rising edges.
- R7: While no frame is in progress, `sclk_o`, `sdo_o` and `latch_o` are all low.
- R8: A start that arrives while busy is ignored. The running frame keeps the word and key captured when its start was accepted, and it ends at its normal time.
- R9: `done_o` is high for exactly one system clock cycle at the end of each frame. In that same cycle `busy_o` is low.
- R10: After reset, `busy_o`, `done_o`, `sclk_o`, `sdo_o` and `latch_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to send a frame; taken only when idle |
| word_i | input | 24 | Word to transmit, captured on acceptance |
| key_i | input | 5 | Latch-enable length in serial clocks (0..31, clamped to 24) |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse when a frame ends |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data, MSB first |
| latch_o | output | 1 | Latch-enable to the driver |

## Verification
A wrong bit counter or shift register shows up within one frame. The word reassembled from the rising-edge samples of `sdo_o` no longer matches, or the `latch_o` samples stop forming a contiguous trailing run of the expected length. A miscounted divider or frame length moves the done pulse away from the `48*HALF_DIV` cycle mark, and this is seen at the end of the first frame. A start leaking through while busy corrupts the captured word or the frame length of the frame in progress, and the bench probes exactly this by asserting start mid-frame with a different word and key.

// File: rtl/led_key_pkg.sv
package led_key_pkg;

    localparam int FRAME_LEN = 24;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam int KEY_W     = 5;

    typedef logic [FRAME_LEN-1:0] word_t;
    typedef logic [CNT_W-1:0]     cnt_t;
    typedef logic [KEY_W-1:0]     key_t;

    typedef enum logic {
        ST_IDLE,
        ST_SEND
    } tx_state_e;

    // Limit a requested key length to the frame length.
    function automatic cnt_t clamp_key(key_t k);
        if (int'(k) > FRAME_LEN) return cnt_t'(FRAME_LEN);
        return cnt_t'(k);
    endfunction

    // Index of the first serial clock cycle that carries latch-enable.
    function automatic cnt_t first_key_cycle(cnt_t n);
        return cnt_t'(FRAME_LEN) - n;
    endfunction

endpackage

// File: rtl/lk_half_divider.sv
module lk_half_divider #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic edge_o
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign edge_o = run && (cnt == LAST);

    // R1
    div_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));
endmodule

// File: rtl/lk_shift_out.sv
module lk_shift_out
    import led_key_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t word_i,
    input  logic  shift,
    output logic  sdo_o
);
    word_t sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (load) begin
            sh <= word_i;
        end else if (shift) begin
            sh <= {sh[FRAME_LEN-2:0], 1'b0};
        end
    end

    assign sdo_o = sh[FRAME_LEN-1];
endmodule

// File: rtl/lk_key_counter.sv
module lk_key_counter
    import led_key_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  key_t key_i,
    input  logic fall,
    output logic latch_o,
    output logic last_o
);
    cnt_t cyc;
    cnt_t nkey;
    cnt_t nxt;
    cnt_t req;
    logic lat;

    assign req    = clamp_key(key_i);
    assign nxt    = cyc + 1'b1;
    assign last_o = fall && (cyc == cnt_t'(FRAME_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc  <= '0;
            nkey <= '0;
            lat  <= 1'b0;
        end else if (load) begin
            cyc  <= '0;
            nkey <= req;
            lat  <= (req == cnt_t'(FRAME_LEN));
        end else if (fall) begin
            if (last_o) begin
                cyc <= '0;
                lat <= 1'b0;
            end else begin
                cyc <= nxt;
                lat <= (nxt >= first_key_cycle(nkey));
            end
        end
    end

    assign latch_o = lat;

    // R1
    cycle_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cyc <= cnt_t'(FRAME_LEN - 1));

    // R3
    latch_falls_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lat) |-> $past(last_o));
endmodule

// File: rtl/key_frame_tx.sv
module key_frame_tx
    import led_key_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [23:0] word_i,
    input  logic [4:0]  key_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        sclk_o,
    output logic        sdo_o,
    output logic        latch_o
);
    tx_state_e state;
    logic      sclk_q;
    logic      done_q;
    logic      tick;
    logic      fall;
    logic      last;
    logic      accept;

    assign accept = start_i && (state == ST_IDLE);
    assign fall   = tick && sclk_q;

    lk_half_divider #(.HALF_DIV(HALF_DIV)) i_div (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_SEND),
        .edge_o (tick)
    );

    lk_shift_out i_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .word_i (word_t'(word_i)),
        .shift  (fall),
        .sdo_o  (sdo_o)
    );

    lk_key_counter i_key (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .key_i   (key_t'(key_i)),
        .fall    (fall),
        .latch_o (latch_o),
        .last_o  (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state  <= ST_SEND;
                sclk_q <= 1'b0;
            end else if (state == ST_SEND && tick) begin
                sclk_q <= ~sclk_q;
                if (last) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy_o = (state == ST_SEND);
    assign done_o = done_q;
    assign sclk_o = sclk_q;

    // R7
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!sclk_o && !sdo_o && !latch_o));

    // R2
    sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> $stable(sdo_o));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> $stable(latch_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: tb/test_key_frame_tx.sv
module test_key_frame_tx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int FRAME      = 24;
    localparam int FRAME_CYC  = 2 * FRAME * HALF_DIV;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [23:0] word_i = '0;
    logic [4:0]  key_i = '0;
    logic        busy_o, done_o, sclk_o, sdo_o, latch_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_frame_tx #(.HALF_DIV(HALF_DIV)) i_key_frame_tx (
        .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i), .key_i(key_i),
        .busy_o(busy_o), .done_o(done_o), .sclk_o(sclk_o), .sdo_o(sdo_o), .latch_o(latch_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int eff_key(input logic [4:0] k);
        return (int'(k) > FRAME) ? FRAME : int'(k);
    endfunction

    function automatic logic [23:0] latch_mask(input logic [4:0] k);
        logic [24:0] m;
        m = (25'd1 << eff_key(k)) - 25'd1;
        return m[23:0];
    endfunction

    // Send one frame; optionally poke a start with other values mid-frame.
    task automatic run_frame(input logic [23:0] w, input logic [4:0] k, input bit poke);
        logic [23:0] got_w;
        logic [23:0] got_l;
        int rises;
        int n;
        bit prev;
        bit seen;
        got_w = '0; got_l = '0; rises = 0; seen = 0;
        @(negedge clk);
        start_i = 1'b1; word_i = w; key_i = k;
        @(negedge clk);
        start_i = 1'b0; word_i = ~w; key_i = ~k;
        chk(busy_o == 1'b1, "R1", "busy after start", 32'(busy_o), 32'd1);
        prev = sclk_o;
        n = 0;
        while (!seen && n < FRAME_CYC + 10) begin
            if (poke && n == 20) start_i = 1'b1;
            if (poke && n == 21) start_i = 1'b0;
            @(negedge clk);
            n++;
            if (sclk_o && !prev) begin
                rises++;
                got_w = {got_w[22:0], sdo_o};
                got_l = {got_l[22:0], latch_o};
            end
            prev = sclk_o;
            if (done_o) seen = 1;
        end
        chk(seen, "R1", "done seen", 32'(seen), 32'd1);
        chk(n == FRAME_CYC, "R1", "frame length", 32'(n), 32'(FRAME_CYC));
        chk(rises == FRAME, "R1", "rising edges", 32'(rises), 32'(FRAME));
        chk(got_w == w, poke ? "R8" : "R2", "serial word", 32'(got_w), 32'(w));
        if (k == 5'd0)
            chk(got_l == '0, "R4", "no latch pulse", 32'(got_l), 32'd0);
        else if (int'(k) > FRAME)
            chk(got_l == latch_mask(k), "R5", "clamped latch", 32'(got_l), 32'(latch_mask(k)));
        else if (k == 5'd2)
            chk(got_l == latch_mask(k), "R6", "data-latch key", 32'(got_l), 32'(latch_mask(k)));
        else
            chk(got_l == latch_mask(k), "R3", "latch window", 32'(got_l), 32'(latch_mask(k)));
        chk(!busy_o, "R9", "busy low with done", 32'(busy_o), 32'd0);
        chk(!sclk_o && !sdo_o && !latch_o, "R7", "lines idle at done",
            32'({sclk_o, sdo_o, latch_o}), 32'd0);
        @(negedge clk);
        chk(!done_o, "R9", "done one cycle", 32'(done_o), 32'd0);
        chk(!busy_o && !sclk_o && !latch_o && !sdo_o, "R7", "idle after frame",
            32'({busy_o, sclk_o, latch_o, sdo_o}), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy_o, done_o, sclk_o, sdo_o, latch_o} == '0, "R10", "reset state",
            32'({busy_o, done_o, sclk_o, sdo_o, latch_o}), 32'd0);

        run_frame(24'hA5C3_0F, 5'd2, 1'b0);
        run_frame(24'h80_0001, 5'd0, 1'b0);
        run_frame(24'hFFFFFF, 5'd24, 1'b0);
        run_frame(24'h123456, 5'd31, 1'b0);
        run_frame(24'h000001, 5'd1, 1'b0);
        run_frame(24'h7E_8181, 5'd23, 1'b0);
        run_frame(24'h3C_5AA5, 5'd25, 1'b0);
        run_frame(24'hC0FFEE, 5'd4, 1'b1);

        for (int i = 0; i < 24; i++) begin
            run_frame(24'($urandom), 5'($urandom), (i % 4) == 0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule